// File: doc/BRIEF.md
# Per-Tenant Bandwidth Telemetry and Admission Governor

This block sits beside a shared memory channel arbiter and keeps the books for up to eight tenants. For every tenant it totals the bytes the channel served, counts contract-violation events and tracks the deepest queue occupancy it saw. It does this over a measurement window whose length in clock cycles is set by an input. On the last cycle of each window the totals are frozen into a snapshot register set, a one-cycle valid strobe is raised, and the live counters start again from zero.

The block also governs guaranteed-rate reservations. A request to reserve a rate for a new bulk transfer is granted only if the sum of all standing reservations plus the new rate stays within 85 percent of the channel capacity. A granted rate joins the running sum, and a release input takes a rate out again. A third function trims burst allowances when an external power monitor reports that the budget is exceeded. At each window boundary with the flag raised, the tenants in the least important priority class that can still be trimmed have their burst allowance halved. Priority value 0 is the most important, and those tenants are never trimmed. A window that ends with the flag low restores every allowance to its base value.

Top module: `bw_governor`

## Requirements
- R1: A window lasts `win_len` cycles, counted from reset release. `snap_vld` is high for exactly one cycle, in the cycle after the last cycle of each window. Values of `win_len` of 0 or 1 make every cycle a window end.
- R2: `snap_bytes` slice t (ACC_W bits at offset t*ACC_W) equals the sum of `served_bytes` slice t over every cycle of the window in which `served_vld[t]` was high, including the window's last cycle. The next window starts counting from zero.
- R3: Byte and violation totals saturate at their all-ones value instead of wrapping, and they still clear at the next window.
- R4: `snap_viol` slice t equals the number of cycles of the window in which `viol_pulse[t]` was high.
- R5: `snap_qmax` slice t equals the largest `queue_depth` slice t value presented during the window, or 0 if none was larger.
- R6: An `adm_req` is answered in the next cycle by `adm_done` high for one cycle. `adm_ok` is 1 exactly when (standing sum + `adm_rate`) * 20 <= `cap_rate` * 17.
- R7: A granted rate is added to `guar_sum` and a refused one leaves it unchanged. A `rel_req` subtracts `rel_rate`, with a floor at 0. A release in the same cycle as a request is applied before the request is judged.
- R8: At a window end with `pwr_over` high, every tenant whose priority equals the largest nonzero priority value among tenants not yet at the floor has `burst_allow` halved (base shifted right by one more bit). Priority-0 tenants keep their base value.
- R9: A tenant is halved at most MAX_HALV times. After that the trimming moves on to the next smaller nonzero priority value.
- R10: A window end with `pwr_over` low restores every `burst_allow` slice to its `burst_base` slice. `pwr_over` is only sampled at window ends.
- R11: While `rst` is high, `snap_vld`, `adm_done`, `adm_ok`, `guar_sum`, all snapshot outputs and `burst_allow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_len | input | WIN_W | Window length in cycles |
| served_vld | input | NTEN | Per-tenant served-transfer strobe |
| served_bytes | input | NTEN*BYTE_W | Per-tenant byte count for the strobe |
| viol_pulse | input | NTEN | Per-tenant contract-violation pulse |
| queue_depth | input | NTEN*QD_W | Per-tenant current queue depth |
| snap_vld | output | 1 | Snapshot published strobe |
| snap_bytes | output | NTEN*ACC_W | Snapshot of bytes served |
| snap_viol | output | NTEN*VIOL_W | Snapshot of violation counts |
| snap_qmax | output | NTEN*QD_W | Snapshot of peak queue depth |
| adm_req | input | 1 | Reservation request |
| adm_rate | input | RATE_W | Requested guaranteed rate |
| rel_req | input | 1 | Reservation release |
| rel_rate | input | RATE_W | Released rate |
| cap_rate | input | RATE_W+clog2(NTEN)+1 | Channel capacity in rate units |
| adm_done | output | 1 | Reservation answer strobe |
| adm_ok | output | 1 | Reservation granted |
| guar_sum | output | RATE_W+clog2(NTEN)+1 | Standing sum of guaranteed rates |
| pwr_over | input | 1 | Power over budget flag |
| tenant_prio | input | NTEN*PRIO_W | Per-tenant priority, 0 most important |
| burst_base | input | NTEN*BURST_W | Per-tenant untrimmed burst allowance |
| burst_allow | output | NTEN*BURST_W | Per-tenant current burst allowance |

## Verification
The bench aims at the window edge. Traffic on the last cycle must land in the closing snapshot and not in the next one. A design that cleared one cycle late or early would put those bytes in the wrong window, or keep stale counts. Saturation is driven past the all-ones value, where a wrapping counter would show a small number, and the following window then shows whether the saturated counter still clears. The reservation check is probed at exactly 85 percent, where a strict comparison would wrongly refuse, and one unit above it. A release and a request are also issued together: judging the request before applying the release would refuse it. The trimming sequence is run across several windows, with two tenants sharing each priority class. A wrong search order, trimming of priority 0, or a missing floor shows up as wrong allowance values, and a flag that drops before the window end must trim nothing.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  // Reservation limit expressed as a ratio: sum * ADM_DEN <= cap * ADM_NUM
  localparam int ADM_NUM = 17;
  localparam int ADM_DEN = 20;
endpackage

// File: rtl/bwg_window_timer.sv
module bwg_window_timer #(
  parameter int WIN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_end
);
  logic [WIN_W-1:0] cnt;

  always_comb begin
    win_end = (win_len <= WIN_W'(1)) || (cnt >= win_len - WIN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (win_end) cnt <= '0;
    else cnt <= cnt + WIN_W'(1);
  end

  // R1: with a steady window length the count never runs past it
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    (win_len > WIN_W'(1) && $past(win_len) == win_len) |-> cnt < win_len);
endmodule

// File: rtl/bwg_tenant_acct.sv
module bwg_tenant_acct #(
  parameter int BYTE_W = 16,
  parameter int ACC_W  = 20,
  parameter int QD_W   = 8,
  parameter int VIOL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_end,
  input  logic              srv_vld,
  input  logic [BYTE_W-1:0] srv_bytes,
  input  logic              viol,
  input  logic [QD_W-1:0]   qdepth,
  output logic [ACC_W-1:0]  snap_bytes,
  output logic [VIOL_W-1:0] snap_viol,
  output logic [QD_W-1:0]   snap_qmax
);
  logic [ACC_W-1:0]  acc_b, nx_b;
  logic [ACC_W:0]    wide_b;
  logic [VIOL_W-1:0] acc_v, nx_v;
  logic [QD_W-1:0]   acc_q, nx_q;

  always_comb begin
    wide_b = {1'b0, acc_b} + (srv_vld ? (ACC_W+1)'(srv_bytes) : '0);
    nx_b   = wide_b[ACC_W] ? '1 : wide_b[ACC_W-1:0];
    nx_v   = (viol && (acc_v != '1)) ? acc_v + VIOL_W'(1) : acc_v;
    nx_q   = (qdepth > acc_q) ? qdepth : acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_b <= '0; acc_v <= '0; acc_q <= '0;
      snap_bytes <= '0; snap_viol <= '0; snap_qmax <= '0;
    end else if (win_end) begin
      snap_bytes <= nx_b; snap_viol <= nx_v; snap_qmax <= nx_q;
      acc_b <= '0; acc_v <= '0; acc_q <= '0;
    end else begin
      acc_b <= nx_b; acc_v <= nx_v; acc_q <= nx_q;
    end
  end

  // R3: a saturated byte total stays put until the window closes
  assert_sat_hold_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(acc_b) == '1 && !$past(win_end)) |-> acc_b == '1);
  // R2: inside a window the byte total never decreases
  assert_bytes_mono_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(win_end) |-> acc_b >= $past(acc_b));
  // R4: violation count grows by at most one per cycle
  assert_viol_step_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(win_end) |-> (acc_v - $past(acc_v)) <= VIOL_W'(1));
endmodule

// File: rtl/bwg_admit.sv
module bwg_admit
  import bwg_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int NTEN   = 8,
  localparam int SUM_W = RATE_W + $clog2(NTEN) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adm_req,
  input  logic [RATE_W-1:0] adm_rate,
  input  logic              rel_req,
  input  logic [RATE_W-1:0] rel_rate,
  input  logic [SUM_W-1:0]  cap,
  output logic              adm_done,
  output logic              adm_ok,
  output logic [SUM_W-1:0]  sum_q
);
  localparam int MW = SUM_W + 6;

  logic [SUM_W-1:0] rel_ext, base;
  logic [SUM_W:0]   cand;
  logic [MW-1:0]    lhs, rhs;
  logic             fits;

  always_comb begin
    rel_ext = SUM_W'(rel_rate);
    base    = sum_q;
    if (rel_req) base = (rel_ext >= sum_q) ? '0 : sum_q - rel_ext;
    cand = {1'b0, base} + (SUM_W+1)'(adm_rate);
    lhs  = MW'(cand) * MW'(ADM_DEN);
    rhs  = MW'(cap) * MW'(ADM_NUM);
    fits = (lhs <= rhs);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0; adm_done <= 1'b0; adm_ok <= 1'b0;
    end else begin
      adm_done <= adm_req;
      adm_ok   <= adm_req && fits;
      sum_q    <= (adm_req && fits) ? cand[SUM_W-1:0] : base;
    end
  end

  // R6: every answer follows a request one cycle earlier
  assert_resp_R6: assert property (@(posedge clk) disable iff (rst)
    adm_done |-> $past(adm_req));
  // R6: a granted request never leaves the sum above the limit
  assert_limit_R6: assert property (@(posedge clk) disable iff (rst)
    (adm_done && adm_ok) |-> MW'(sum_q) * MW'(ADM_DEN) <= MW'($past(cap)) * MW'(ADM_NUM));
  // R7: a refusal without a release leaves the sum unchanged
  assert_reject_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (adm_done && !adm_ok && !$past(rel_req)) |-> sum_q == $past(sum_q));
endmodule

// File: rtl/bwg_burst_ctl.sv
module bwg_burst_ctl #(
  parameter int NTEN     = 8,
  parameter int PRIO_W   = 3,
  parameter int BURST_W  = 16,
  parameter int MAX_HALV = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    win_end,
  input  logic                    pwr_over,
  input  logic [NTEN*PRIO_W-1:0]  prio,
  input  logic [NTEN*BURST_W-1:0] base,
  output logic [NTEN*BURST_W-1:0] allow
);
  localparam int SH_W = $clog2(MAX_HALV + 1);

  logic [PRIO_W-1:0] prio_a [NTEN];
  logic [SH_W-1:0]   sh_q   [NTEN];
  logic [SH_W-1:0]   sh_d   [NTEN];
  logic [PRIO_W-1:0] lvl;

  // Least important class that still has a tenant above the floor
  always_comb begin
    lvl = '0;
    for (int i = 0; i < NTEN; i++) begin
      if (prio_a[i] != '0 && sh_q[i] < SH_W'(MAX_HALV) && prio_a[i] > lvl)
        lvl = prio_a[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NTEN; i++) begin
      sh_d[i] = sh_q[i];
      if (win_end) begin
        if (!pwr_over) sh_d[i] = '0;
        else if (lvl != '0 && prio_a[i] == lvl && sh_q[i] < SH_W'(MAX_HALV))
          sh_d[i] = sh_q[i] + SH_W'(1);
      end
    end
  end

  for (genvar g = 0; g < NTEN; g++) begin : g_ten
    assign prio_a[g] = prio[g*PRIO_W +: PRIO_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        sh_q[g] <= '0;
        allow[g*BURST_W +: BURST_W] <= '0;
      end else begin
        sh_q[g] <= sh_d[g];
        allow[g*BURST_W +: BURST_W] <= base[g*BURST_W +: BURST_W] >> sh_d[g];
      end
    end

    // R8: trimming only ever hits nonzero priorities while over budget
    assert_prio0_keep_R8: assert property (@(posedge clk) disable iff (rst)
      (sh_q[g] > $past(sh_q[g])) |-> ($past(prio_a[g]) != '0 && $past(pwr_over)));
    // R9: never trimmed below the floor
    assert_floor_R9: assert property (@(posedge clk) disable iff (rst)
      sh_q[g] <= SH_W'(MAX_HALV));
    // R10: a quiet window end restores the base allowance
    assert_restore_R10: assert property (@(posedge clk) disable iff (rst)
      ($past(win_end) && !$past(pwr_over)) |-> sh_q[g] == '0);
  end
endmodule

// File: rtl/bw_governor.sv
module bw_governor #(
  parameter int NTEN     = 8,
  parameter int BYTE_W   = 16,
  parameter int ACC_W    = 20,
  parameter int QD_W     = 8,
  parameter int VIOL_W   = 8,
  parameter int WIN_W    = 24,
  parameter int RATE_W   = 16,
  parameter int PRIO_W   = 3,
  parameter int BURST_W  = 16,
  parameter int MAX_HALV = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [WIN_W-1:0]                win_len,
  input  logic [NTEN-1:0]                 served_vld,
  input  logic [NTEN*BYTE_W-1:0]          served_bytes,
  input  logic [NTEN-1:0]                 viol_pulse,
  input  logic [NTEN*QD_W-1:0]            queue_depth,
  output logic                            snap_vld,
  output logic [NTEN*ACC_W-1:0]           snap_bytes,
  output logic [NTEN*VIOL_W-1:0]          snap_viol,
  output logic [NTEN*QD_W-1:0]            snap_qmax,
  input  logic                            adm_req,
  input  logic [RATE_W-1:0]               adm_rate,
  input  logic                            rel_req,
  input  logic [RATE_W-1:0]               rel_rate,
  input  logic [RATE_W+$clog2(NTEN):0]    cap_rate,
  output logic                            adm_done,
  output logic                            adm_ok,
  output logic [RATE_W+$clog2(NTEN):0]    guar_sum,
  input  logic                            pwr_over,
  input  logic [NTEN*PRIO_W-1:0]          tenant_prio,
  input  logic [NTEN*BURST_W-1:0]         burst_base,
  output logic [NTEN*BURST_W-1:0]         burst_allow
);
  logic win_end;

  bwg_window_timer #(.WIN_W(WIN_W)) u_timer (
    .clk(clk), .rst(rst), .win_len(win_len), .win_end(win_end)
  );

  always_ff @(posedge clk) begin
    if (rst) snap_vld <= 1'b0;
    else snap_vld <= win_end;
  end

  for (genvar t = 0; t < NTEN; t++) begin : g_acct
    bwg_tenant_acct #(
      .BYTE_W(BYTE_W), .ACC_W(ACC_W), .QD_W(QD_W), .VIOL_W(VIOL_W)
    ) u_acct (
      .clk(clk), .rst(rst), .win_end(win_end),
      .srv_vld(served_vld[t]),
      .srv_bytes(served_bytes[t*BYTE_W +: BYTE_W]),
      .viol(viol_pulse[t]),
      .qdepth(queue_depth[t*QD_W +: QD_W]),
      .snap_bytes(snap_bytes[t*ACC_W +: ACC_W]),
      .snap_viol(snap_viol[t*VIOL_W +: VIOL_W]),
      .snap_qmax(snap_qmax[t*QD_W +: QD_W])
    );
  end

  bwg_admit #(.RATE_W(RATE_W), .NTEN(NTEN)) u_admit (
    .clk(clk), .rst(rst),
    .adm_req(adm_req), .adm_rate(adm_rate),
    .rel_req(rel_req), .rel_rate(rel_rate),
    .cap(cap_rate),
    .adm_done(adm_done), .adm_ok(adm_ok), .sum_q(guar_sum)
  );

  bwg_burst_ctl #(
    .NTEN(NTEN), .PRIO_W(PRIO_W), .BURST_W(BURST_W), .MAX_HALV(MAX_HALV)
  ) u_burst (
    .clk(clk), .rst(rst), .win_end(win_end), .pwr_over(pwr_over),
    .prio(tenant_prio), .base(burst_base), .allow(burst_allow)
  );

  // R1: with a window longer than one cycle the strobe never repeats back to back
  assert_snap_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    (snap_vld && win_len > WIN_W'(1) && $stable(win_len)) |=> !snap_vld);
endmodule

// File: tb/bw_governor_bench.sv
module bw_governor_bench;
  localparam int NT = 8, BW = 16, AW = 20, QW = 8, VW = 8, WW = 24;
  localparam int RW = 16, PW = 3, UW = 16, MH = 4, SW = RW + 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic [WW-1:0] win_len;
  logic [NT-1:0] served_vld, viol_pulse;
  logic [NT*BW-1:0] served_bytes;
  logic [NT*QW-1:0] queue_depth;
  logic snap_vld, adm_req, rel_req, adm_done, adm_ok, pwr_over;
  logic [NT*AW-1:0] snap_bytes;
  logic [NT*VW-1:0] snap_viol;
  logic [NT*QW-1:0] snap_qmax;
  logic [RW-1:0] adm_rate, rel_rate;
  logic [SW-1:0] cap_rate, guar_sum;
  logic [NT*PW-1:0] tenant_prio;
  logic [NT*UW-1:0] burst_base, burst_allow;

  bw_governor u_bw_governor (
    .clk(clk), .rst(rst), .win_len(win_len),
    .served_vld(served_vld), .served_bytes(served_bytes),
    .viol_pulse(viol_pulse), .queue_depth(queue_depth),
    .snap_vld(snap_vld), .snap_bytes(snap_bytes), .snap_viol(snap_viol),
    .snap_qmax(snap_qmax), .adm_req(adm_req), .adm_rate(adm_rate),
    .rel_req(rel_req), .rel_rate(rel_rate), .cap_rate(cap_rate),
    .adm_done(adm_done), .adm_ok(adm_ok), .guar_sum(guar_sum),
    .pwr_over(pwr_over), .tenant_prio(tenant_prio),
    .burst_base(burst_base), .burst_allow(burst_allow)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    served_vld = '0; served_bytes = '0; viol_pulse = '0; queue_depth = '0;
    adm_req = 1'b0; adm_rate = '0; rel_req = 1'b0; rel_rate = '0;
  endtask

  task automatic do_reset(input int len);
    @(negedge clk);
    rst = 1'b1; win_len = WW'(len); clear_in();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // R11: values held under reset
  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; win_len = WW'(8); clear_in();
    repeat (3) @(negedge clk);
    check("R11 snap_vld", snap_vld, 0);
    check("R11 adm_done", adm_done, 0);
    check("R11 guar_sum", guar_sum, 0);
    check("R11 snap_bytes", (snap_bytes == '0), 1);
    check("R11 burst_allow", (burst_allow == '0), 1);
  endtask

  // R1 R2 R4 R5: ordinary windows, last-cycle inclusion and clearing
  task automatic t_window();
    int eb[NT], ev[NT], eq[NT];
    for (int t = 0; t < NT; t++) begin eb[t] = 0; ev[t] = 0; eq[t] = 0; end
    do_reset(8);
    for (int i = 0; i < 8; i++) begin
      for (int t = 0; t < NT; t++) begin
        served_vld[t] = ((i + t) % 2 == 0);
        served_bytes[t*BW +: BW] = BW'((t + 1) * (i + 1) * 37);
        viol_pulse[t] = (i < t);
        queue_depth[t*QW +: QW] = QW'((i * 3 + t * 5) % 17);
        if ((i + t) % 2 == 0) eb[t] += (t + 1) * (i + 1) * 37;
        if (i < t) ev[t]++;
        if ((i * 3 + t * 5) % 17 > eq[t]) eq[t] = (i * 3 + t * 5) % 17;
      end
      if (i == 4) check("R1 no strobe mid-window", snap_vld, 0);
      @(negedge clk);
    end
    check("R1 strobe at window end", snap_vld, 1);
    for (int t = 0; t < NT; t++) begin
      check("R2 bytes window1", snap_bytes[t*AW +: AW], eb[t]);
      check("R4 viol window1", snap_viol[t*VW +: VW], ev[t]);
      check("R5 qmax window1", snap_qmax[t*QW +: QW], eq[t]);
    end
    clear_in();
    for (int i = 0; i < 8; i++) begin
      clear_in();
      if (i == 0) begin served_vld[2] = 1'b1; served_bytes[2*BW +: BW] = 16'd7; end
      if (i == 7) begin viol_pulse[5] = 1'b1; queue_depth[1*QW +: QW] = 8'd3; end
      if (i == 1) check("R1 strobe one cycle", snap_vld, 0);
      @(negedge clk);
    end
    clear_in();
    check("R1 strobe window2", snap_vld, 1);
    for (int t = 0; t < NT; t++) begin
      check("R2 bytes cleared window2", snap_bytes[t*AW +: AW], (t == 2) ? 7 : 0);
      check("R4 viol last cycle", snap_viol[t*VW +: VW], (t == 5) ? 1 : 0);
      check("R5 qmax window2", snap_qmax[t*QW +: QW], (t == 1) ? 3 : 0);
    end
  endtask

  // R3: saturation and clearing after it
  task automatic t_saturate();
    do_reset(300);
    for (int i = 0; i < 300; i++) begin
      served_vld = '1; served_bytes = '1; viol_pulse = '1;
      @(negedge clk);
    end
    clear_in();
    for (int t = 0; t < NT; t++) begin
      check("R3 bytes saturate", snap_bytes[t*AW +: AW], (1 << AW) - 1);
      check("R3 viol saturate", snap_viol[t*VW +: VW], (1 << VW) - 1);
    end
    for (int i = 0; i < 300; i++) begin
      clear_in();
      if (i == 0) viol_pulse[0] = 1'b1;
      @(negedge clk);
    end
    clear_in();
    check("R3 bytes clear after sat", snap_bytes[0 +: AW], 0);
    check("R3 viol clear after sat", snap_viol[0 +: VW], 1);
  endtask

  task automatic adm_op(input string tag, input bit a, input int ar, input bit r,
                        input int rr, input bit exp_ok, input int exp_sum);
    adm_req = a; adm_rate = RW'(ar); rel_req = r; rel_rate = RW'(rr);
    @(negedge clk);
    clear_in();
    check({tag, " done"}, adm_done, a);
    if (a) check({tag, " ok"}, adm_ok, exp_ok);
    check({tag, " sum"}, guar_sum, exp_sum);
    @(negedge clk);
    check({tag, " done single"}, adm_done, 0);
  endtask

  // R6 R7: reservation limit at 17/20 of capacity
  task automatic t_admission();
    cap_rate = SW'(1000);
    do_reset(1000);
    adm_op("R6 exact limit", 1, 850, 0, 0, 1, 850);
    adm_op("R6 one over", 1, 1, 0, 0, 0, 850);
    adm_op("R7 release", 0, 0, 1, 100, 0, 750);
    adm_op("R7 release first", 1, 200, 1, 100, 1, 850);
    adm_op("R7 release floor", 0, 0, 1, 5000, 0, 0);
    adm_op("R6 reject from empty", 1, 851, 0, 0, 0, 0);
    adm_op("R7 grant adds", 1, 300, 0, 0, 1, 300);
  endtask

  function automatic int base_of(input int t);
    return 256 + t * 16;
  endfunction

  function automatic int prio_of(input int t);
    int p[NT] = '{0, 1, 2, 3, 3, 2, 1, 0};
    return p[t];
  endfunction

  task automatic burst_check(input string tag, input int s3, input int s2);
    for (int t = 0; t < NT; t++) begin
      int s;
      s = (prio_of(t) == 3) ? s3 : (prio_of(t) == 2) ? s2 : 0;
      check(tag, burst_allow[t*UW +: UW], base_of(t) >> s);
    end
  endtask

  // R8 R9 R10: trimming order, floor and restore
  task automatic t_burst();
    for (int t = 0; t < NT; t++) begin
      tenant_prio[t*PW +: PW] = PW'(prio_of(t));
      burst_base[t*UW +: UW] = UW'(base_of(t));
    end
    pwr_over = 1'b1;
    do_reset(4);
    for (int w = 1; w <= 6; w++) begin
      repeat (4) @(negedge clk);
      if (w <= MH) burst_check("R8 halve lowest class", w, 0);
      else burst_check("R9 floor then next class", MH, w - MH);
    end
    pwr_over = 1'b0;
    repeat (4) @(negedge clk);
    burst_check("R10 restore", 0, 0);
    pwr_over = 1'b1;
    repeat (2) @(negedge clk);
    pwr_over = 1'b0;
    repeat (2) @(negedge clk);
    burst_check("R10 flag only at window end", 0, 0);
    pwr_over = 1'b1;
    repeat (4) @(negedge clk);
    burst_check("R8 restart from lowest class", 1, 0);
    pwr_over = 1'b0;
  endtask

  initial begin
    rst = 1'b1; win_len = WW'(8); cap_rate = '0; pwr_over = 1'b0;
    tenant_prio = '0; burst_base = '0; clear_in();
    t_reset();
    t_window();
    t_saturate();
    t_admission();
    t_burst();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule